// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Unit

This unit sits between a host bus master and up to eight external devices. It decodes each host address into one of eight active-low select lines and drives the strobes for that access: a read enable, four byte-lane write enables and a read/write level. It ends each data beat with a transfer acknowledge. When an access cannot be served, it ends the access with an error pulse instead.

Channels 0 and 1 each compare the address against their own base register, using their own mask of don't-care bits. Channels 2 to 7 share one 2 MB-aligned start register and take consecutive fixed 2 MB slots above it. Channel 0 comes out of reset already enabled over a boot window, so code can be fetched before any register is written. Each channel has its own control word. It picks the port width, which limits the byte lanes written, and a wait count from 0 to 15 or termination by an external acknowledge input. It also holds a burst permission bit and a write-protect bit.

A host burst is four beats at one latched address. A channel with burst permission keeps its select line low across all four beats. A channel without it turns the burst into four separate single accesses. The transfer-in-progress output stays high for the whole operation.

Top module: `chip_select_unit`

## Requirements
- R1: While reset is high and after it is released, `sel_n` reads 8'hFF, `rd_n`, `rw_n` read 1, `wr_n` reads 4'hF, and `busy`, `ack`, `err` read 0. Out of reset, channel 0 is enabled with base 0 and mask 32'h000F_FFFF. It has 15 wait states, a 32-bit port, burst and protection off. All other channels are disabled.
- R2: Channel 0 matches when `((addr ^ base0) & ~mask0) == 0`. Channel 1 uses the same test with its own registers. `cfg_addr` 8 writes base0, 9 writes mask0, 10 writes base1 and 11 writes mask1.
- R3: Writing `cfg_addr` 12 sets the shared start to `cfg_wdata` with bits 20:0 cleared. Channel n (2..7) matches when `(addr - start) >> 21 == n - 2`, computed in 32-bit unsigned arithmetic.
- R4: Among the enabled channels that match, the lowest-numbered one is selected. An address that matches no enabled channel selects no line and gives `err` for one cycle.
- R5: `cfg_addr` 0..7 writes the control word of that channel from `cfg_wdata`, which has this layout:
  - bit 0: enable
  - bits 2:1: port width (0 = 32, 1 = 8, 2 = 16, 3 = 32)
  - bits 6:3: wait count
  - bit 7: external acknowledge
  - bit 8: burst permission
  - bit 9: write protect
- R6: A request is taken on a rising edge where `req_valid` is 1 and `busy` is 0. In wait mode, the selected `sel_n` bit is low from the next cycle for wait+1 cycles, and `ack` is 1 in the last of them.
- R7: In external-acknowledge mode, `ack` equals `ext_ack` in every cycle in which a select line is low, and the wait count has no effect. In wait mode, `ext_ack` has no effect.
- R8: During a read beat `rd_n` is 0 and `wr_n` is 4'hF. During a write beat `rd_n` is 1, and `wr_n[k]` is 0 exactly when `req_be[k]` is 1 and lane k belongs to the port: all lanes for 32-bit, lanes 3:2 for 16-bit, lane 3 for 8-bit. `rw_n` is 0 while `busy` is high for a write, and 1 otherwise.
- R9: A burst request to a channel with burst permission gives four beats of wait+1 cycles each with no gap. `sel_n` stays low throughout, and each beat ends with `ack`.
- R10: A burst request to a channel without burst permission gives four single beats, each with its full wait count. One cycle with all `sel_n` high and no strobes separates consecutive beats, and `busy` stays high.
- R11: A write to a write-protected channel drives no select line and no write enable. It ends with one cycle of `err`, once even for a burst. Reads from that channel are served normally.
- R12: `req_valid` is ignored while `busy` is high, including in the cycle of the final `ack`.
- R13: `busy` is high from the cycle after acceptance through the cycle of the final `ack` or `err`, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Host access request |
| req_addr | input | 32 | Host byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst |
| req_be | input | 4 | Byte lanes the host wants written |
| ext_ack | input | 1 | External acknowledge from the device |
| sel_n | output | 8 | Active-low channel selects |
| rd_n | output | 1 | Active-low read enable |
| wr_n | output | 4 | Active-low byte write enables |
| rw_n | output | 1 | Read/write level, low for writes |
| busy | output | 1 | Transfer in progress |
| ack | output | 1 | Beat acknowledge |
| err | output | 1 | Error termination |

## Verification
Two events can fall in the same cycle: a new request arrives while the final acknowledge of the current transfer is being given, and the external acknowledge input toggles while the active channel counts wait states. The bench holds `req_valid` high over the whole of a running transfer, including its last `ack` cycle. It then checks that the outputs return to idle, with no second select. `ext_ack` follows a free-running one-in-three pattern during every access. The reference model predicts each cycle of strobes, so any early or late acknowledge shows up as a cycle mismatch.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int NCH = 8;
    localparam int CHW = $clog2(NCH);

    typedef enum logic [1:0] {
        PS32  = 2'd0,
        PS8   = 2'd1,
        PS16  = 2'd2,
        PS32X = 2'd3
    } psize_e;

    typedef struct packed {
        logic       wp;
        logic       burst;
        logic       ext;
        logic [3:0] wait_n;
        psize_e     psize;
        logic       en;
    } ch_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACT,
        ST_GAP,
        ST_ERR
    } st_e;

    localparam logic [3:0] CFG_BASE0 = 4'd8;
    localparam logic [3:0] CFG_MASK0 = 4'd9;
    localparam logic [3:0] CFG_BASE1 = 4'd10;
    localparam logic [3:0] CFG_MASK1 = 4'd11;
    localparam logic [3:0] CFG_CBASE = 4'd12;

    function automatic logic [3:0] lane_en(psize_e ps, logic [3:0] be);
        case (ps)
            PS8:     return be & 4'b1000;
            PS16:    return be & 4'b1100;
            default: return be;
        endcase
    endfunction

endpackage

// File: rtl/cs_cfg.sv
module cs_cfg
    import cs_pkg::*;
#(
    parameter int              AW        = 32,
    parameter int              SLOT_LOG2 = 21,
    parameter logic [AW-1:0]   BOOT_MASK = 32'h000F_FFFF,
    parameter logic [3:0]      BOOT_WAIT = 4'd15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [3:0]              cfg_addr,
    input  logic [AW-1:0]           cfg_wdata,
    output ch_ctrl_t [NCH-1:0]      ctrl,
    output logic [AW-1:0]           base0,
    output logic [AW-1:0]           mask0,
    output logic [AW-1:0]           base1,
    output logic [AW-1:0]           mask1,
    output logic [AW-SLOT_LOG2-1:0] cbase
);
    localparam int CW = $bits(ch_ctrl_t);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) ctrl[i] <= '0;
            ctrl[0] <= '{wp: 1'b0, burst: 1'b0, ext: 1'b0,
                         wait_n: BOOT_WAIT, psize: PS32, en: 1'b1};
            base0 <= '0;
            mask0 <= BOOT_MASK;
            base1 <= '0;
            mask1 <= '0;
            cbase <= '0;
        end else if (cfg_we) begin
            if (!cfg_addr[3]) begin
                ctrl[cfg_addr[CHW-1:0]] <= ch_ctrl_t'(cfg_wdata[CW-1:0]);
            end else begin
                case (cfg_addr)
                    CFG_BASE0: base0 <= cfg_wdata;
                    CFG_MASK0: mask0 <= cfg_wdata;
                    CFG_BASE1: base1 <= cfg_wdata;
                    CFG_MASK1: mask1 <= cfg_wdata;
                    CFG_CBASE: cbase <= cfg_wdata[AW-1:SLOT_LOG2];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cs_decode.sv
module cs_decode
    import cs_pkg::*;
#(
    parameter int AW        = 32,
    parameter int SLOT_LOG2 = 21
) (
    input  logic [AW-1:0]           addr,
    input  logic [AW-1:0]           base0,
    input  logic [AW-1:0]           mask0,
    input  logic [AW-1:0]           base1,
    input  logic [AW-1:0]           mask1,
    input  logic [AW-SLOT_LOG2-1:0] cbase,
    input  logic [NCH-1:0]          en,
    output logic                    hit,
    output logic [CHW-1:0]          ch
);
    localparam int SW = AW - SLOT_LOG2;

    logic [NCH-1:0] match;
    logic [SW-1:0]  slot_off;

    assign slot_off = addr[AW-1:SLOT_LOG2] - cbase;
    assign match[0] = en[0] && (((addr ^ base0) & ~mask0) == '0);
    assign match[1] = en[1] && (((addr ^ base1) & ~mask1) == '0);

    for (genvar g = 2; g < NCH; g++) begin : g_slot
        assign match[g] = en[g] && (slot_off == SW'(g - 2));
    end

    always_comb begin
        hit = 1'b0;
        ch  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                ch  = CHW'(i);
            end
        end
    end
endmodule

// File: rtl/cs_seq.sv
module cs_seq
    import cs_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic           req_burst,
    input  logic [3:0]     req_be,
    input  logic           ext_ack,
    input  logic           hit,
    input  logic [CHW-1:0] ch,
    input  logic           sel_wp,
    input  logic           sel_burst,
    input  logic           sel_ext,
    input  logic [3:0]     sel_wait,
    input  psize_e         sel_psize,
    output logic [NCH-1:0] sel_n,
    output logic           rd_n,
    output logic [3:0]     wr_n,
    output logic           rw_n,
    output logic           busy,
    output logic           ack,
    output logic           err
);
    st_e            st;
    logic [CHW-1:0] ch_q;
    logic           wr_q, ext_q, bsten_q, multi_q;
    logic [3:0]     lanes_q, wait_q, cnt_q;
    logic [1:0]     beat_q;
    logic           active, last_beat;

    assign active    = (st == ST_ACT);
    assign ack       = active && (ext_q ? ext_ack : (cnt_q == 4'd0));
    assign err       = (st == ST_ERR);
    assign busy      = (st != ST_IDLE);
    assign last_beat = !multi_q || (beat_q == 2'd3);
    assign sel_n     = active ? ~(NCH'(1) << ch_q) : '1;
    assign rd_n      = !(active && !wr_q);
    assign wr_n      = (active && wr_q) ? ~lanes_q : 4'hF;
    assign rw_n      = !(busy && wr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ch_q    <= '0;
            wr_q    <= 1'b0;
            ext_q   <= 1'b0;
            bsten_q <= 1'b0;
            multi_q <= 1'b0;
            lanes_q <= '0;
            wait_q  <= '0;
            cnt_q   <= '0;
            beat_q  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    wr_q    <= req_write;
                    multi_q <= req_burst;
                    beat_q  <= '0;
                    ch_q    <= ch;
                    lanes_q <= lane_en(sel_psize, req_be);
                    wait_q  <= sel_wait;
                    cnt_q   <= sel_wait;
                    ext_q   <= sel_ext;
                    bsten_q <= sel_burst;
                    st      <= (!hit || (req_write && sel_wp)) ? ST_ERR : ST_ACT;
                end
                ST_ACT: begin
                    if (ack) begin
                        if (last_beat) begin
                            st <= ST_IDLE;
                        end else begin
                            beat_q <= beat_q + 2'd1;
                            cnt_q  <= wait_q;
                            st     <= bsten_q ? ST_ACT : ST_GAP;
                        end
                    end else if (!ext_q) begin
                        cnt_q <= cnt_q - 4'd1;
                    end
                end
                ST_GAP:  st <= ST_ACT;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/chip_select_unit.sv
module chip_select_unit
    import cs_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            SLOT_LOG2 = 21,
    parameter logic [AW-1:0] BOOT_MASK = 32'h000F_FFFF,
    parameter logic [3:0]    BOOT_WAIT = 4'd15
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [3:0]     cfg_addr,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_addr,
    input  logic           req_write,
    input  logic           req_burst,
    input  logic [3:0]     req_be,
    input  logic           ext_ack,
    output logic [NCH-1:0] sel_n,
    output logic           rd_n,
    output logic [3:0]     wr_n,
    output logic           rw_n,
    output logic           busy,
    output logic           ack,
    output logic           err
);
    ch_ctrl_t [NCH-1:0]      ctrl;
    logic [AW-1:0]           base0, mask0, base1, mask1;
    logic [AW-SLOT_LOG2-1:0] cbase;
    logic [NCH-1:0]          ch_en;
    logic                    dec_hit;
    logic [CHW-1:0]          dec_ch;

    for (genvar g = 0; g < NCH; g++) begin : g_en
        assign ch_en[g] = ctrl[g].en;
    end

    cs_cfg #(.AW(AW), .SLOT_LOG2(SLOT_LOG2), .BOOT_MASK(BOOT_MASK), .BOOT_WAIT(BOOT_WAIT)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .ctrl(ctrl), .base0(base0), .mask0(mask0), .base1(base1), .mask1(mask1), .cbase(cbase)
    );

    cs_decode #(.AW(AW), .SLOT_LOG2(SLOT_LOG2)) u_dec (
        .addr(req_addr), .base0(base0), .mask0(mask0), .base1(base1), .mask1(mask1),
        .cbase(cbase), .en(ch_en), .hit(dec_hit), .ch(dec_ch)
    );

    cs_seq u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_burst(req_burst), .req_be(req_be), .ext_ack(ext_ack),
        .hit(dec_hit), .ch(dec_ch),
        .sel_wp(ctrl[dec_ch].wp), .sel_burst(ctrl[dec_ch].burst), .sel_ext(ctrl[dec_ch].ext),
        .sel_wait(ctrl[dec_ch].wait_n), .sel_psize(ctrl[dec_ch].psize),
        .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n), .rw_n(rw_n),
        .busy(busy), .ack(ack), .err(err)
    );
endmodule

// File: rtl/cs_unit_chk.sv
module cs_unit_chk
    import cs_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] sel_n,
    input logic           rd_n,
    input logic [3:0]     wr_n,
    input logic           busy,
    input logic           ack,
    input logic           err
);
    a_r4_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~sel_n));

    a_r13_ack_in_busy: assert property (@(posedge clk) disable iff (rst)
        (ack || err) |-> busy);

    a_r11_err_quiet: assert property (@(posedge clk) disable iff (rst)
        err |-> (sel_n == '1 && wr_n == 4'hF && !ack));

    a_r8_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (wr_n == 4'hF));

    a_r8_strobe_needs_sel: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || wr_n != 4'hF) |-> (sel_n != '1));

    a_r9_sel_held: assert property (@(posedge clk) disable iff (rst)
        (!ack && sel_n != '1) |=> $stable(sel_n));

    a_r12_busy_held: assert property (@(posedge clk) disable iff (rst)
        (busy && !ack && !err) |=> busy);
endmodule

bind chip_select_unit cs_unit_chk u_cs_unit_chk (
    .clk(clk), .rst(rst), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .busy(busy), .ack(ack), .err(err)
);

// File: tb/chip_select_unit_bench.sv
module chip_select_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_burst = 1'b0;
    logic [3:0]  req_be = 4'hF;
    logic        ext_ack = 1'b0;
    logic [7:0]  sel_n;
    logic        rd_n, rw_n, busy, ack, err;
    logic [3:0]  wr_n;

    always #4 clk = ~clk;

    chip_select_unit u_chip_select_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_burst(req_burst), .req_be(req_be), .ext_ack(ext_ack),
        .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n), .rw_n(rw_n),
        .busy(busy), .ack(ack), .err(err)
    );

    localparam logic [16:0] IDLE_V = {8'hFF, 1'b1, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0};

    int checks = 0;
    int failures = 0;
    int nc = 0;
    bit done = 0;
    logic [16:0] q[$];
    string tq[$];

    int m_en[8], m_ps[8], m_wait[8], m_ext[8], m_bst[8], m_wp[8];
    logic [31:0] m_b0, m_k0, m_b1, m_k1, m_cb;

    task automatic tick();
        logic [16:0] act, expv;
        string tg;
        @(negedge clk);
        nc++;
        req_valid = 1'b0;
        cfg_we = 1'b0;
        ext_ack = (nc % 3 == 0);
        #1;
        act = {sel_n, rd_n, wr_n, rw_n, busy, ack, err};
        if (q.size() > 0) begin
            expv = q.pop_front();
            tg = tq.pop_front();
        end else begin
            expv = IDLE_V;
            tg = "R1 idle";
        end
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", tg, nc, act, expv);
        end
    endtask

    task automatic push(logic [16:0] r, string tg);
        q.push_back(r);
        tq.push_back(tg);
    endtask

    task automatic cfg_write(logic [3:0] a, logic [31:0] d);
        cfg_addr = a;
        cfg_wdata = d;
        cfg_we = 1'b1;
        if (a < 8) begin
            m_en[a] = d[0]; m_ps[a] = d[2:1]; m_wait[a] = d[6:3];
            m_ext[a] = d[7]; m_bst[a] = d[8]; m_wp[a] = d[9];
        end else if (a == 8)  m_b0 = d;
        else if (a == 9)  m_k0 = d;
        else if (a == 10) m_b1 = d;
        else if (a == 11) m_k1 = d;
        else if (a == 12) m_cb = d & 32'hFFE0_0000;
        tick();
    endtask

    function automatic int bdecode(logic [31:0] a);
        for (int n = 0; n < 8; n++) begin
            if (m_en[n] == 0) continue;
            if (n == 0 && ((a ^ m_b0) & ~m_k0) == 0) return 0;
            if (n == 1 && ((a ^ m_b1) & ~m_k1) == 0) return 1;
            if (n >= 2 && ((a - m_cb) >> 21) == n - 2) return n;
        end
        return -1;
    endfunction

    task automatic issue(logic [31:0] a, bit wr, bit bst, logic [3:0] be, string tg);
        int chn, m, nb;
        logic [3:0] lanes;
        logic [7:0] s;
        chn = bdecode(a);
        if (chn < 0 || (wr && m_wp[chn] != 0)) begin
            push({8'hFF, 1'b1, 4'hF, !wr, 1'b1, 1'b0, 1'b1}, tg);
        end else begin
            case (m_ps[chn])
                1: lanes = be & 4'b1000;
                2: lanes = be & 4'b1100;
                default: lanes = be;
            endcase
            s = ~(8'd1 << chn);
            m = nc + 1;
            nb = bst ? 4 : 1;
            for (int b = 0; b < nb; b++) begin
                for (int k = 0; ; k++) begin
                    bit t;
                    t = (m_ext[chn] != 0) ? (m % 3 == 0) : (k == m_wait[chn]);
                    push({s, wr, wr ? ~lanes : 4'hF, !wr, 1'b1, t, 1'b0}, tg);
                    m++;
                    if (t) break;
                end
                if (b < nb - 1 && m_bst[chn] == 0) begin
                    push({8'hFF, 1'b1, 4'hF, !wr, 1'b1, 1'b0, 1'b0}, tg);
                    m++;
                end
            end
        end
        req_addr = a; req_write = wr; req_burst = bst; req_be = be;
        req_valid = 1'b1;
    endtask

    task automatic run(logic [31:0] a, bit wr, bit bst, logic [3:0] be, string tg);
        issue(a, wr, bst, be, tg);
        tick();
        while (q.size() > 0) tick();
        tick();
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_en[i] = 0; m_ps[i] = 0; m_wait[i] = 0; m_ext[i] = 0; m_bst[i] = 0; m_wp[i] = 0;
        end
        m_en[0] = 1; m_wait[0] = 15;
        m_b0 = 0; m_k0 = 32'h000F_FFFF; m_b1 = 0; m_k1 = 0; m_cb = 0;

        // R1: reset state
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 R6: boot channel live before any configuration, 15 waits
        run(32'h0000_0100, 0, 0, 4'hF, "R1 R6 boot read");
        // R8: 32-bit port write lanes follow byte enables
        run(32'h0000_0200, 1, 0, 4'b0101, "R8 boot write lanes");

        // R2 R5 R8: channel 1 16-bit port, 2 waits
        cfg_write(4'd10, 32'h4000_0000);
        cfg_write(4'd11, 32'h0000_FFFF);
        cfg_write(4'd1, 32'h0000_0015);
        run(32'h4000_1234, 1, 0, 4'hF, "R2 R8 ch1 16-bit write");
        run(32'h4001_0000, 0, 0, 4'hF, "R2 R4 outside ch1 window");

        // R3: shared slots
        cfg_write(4'd12, 32'h8001_2345);
        cfg_write(4'd2, 32'h0000_0109);
        cfg_write(4'd3, 32'h0000_0001);
        cfg_write(4'd4, 32'h0000_0201);
        cfg_write(4'd5, 32'h0000_00A9);
        cfg_write(4'd6, 32'h0000_000B);
        cfg_write(4'd7, 32'h0000_0019);
        run(32'h80A0_0000, 0, 0, 4'hF, "R3 slot ch7");
        run(32'h8020_0004, 0, 0, 4'hF, "R3 slot ch3");
        run(32'h80C0_0000, 0, 0, 4'hF, "R3 R4 beyond last slot");
        run(32'h7FFF_FFFC, 0, 0, 4'hF, "R3 R4 below start");
        run(32'h8080_0010, 1, 0, 4'hF, "R8 ch6 8-bit write");

        // R9: burst permitted
        run(32'h8000_0010, 0, 1, 4'hF, "R9 burst held");
        run(32'h8000_0020, 1, 1, 4'b0011, "R9 burst write");
        // R10: burst split
        run(32'h8020_0000, 1, 1, 4'hF, "R10 burst split");
        // R11: write protect
        run(32'h8040_0000, 1, 0, 4'hF, "R11 protected write");
        run(32'h8040_0000, 1, 1, 4'hF, "R11 protected burst write");
        run(32'h8040_0008, 0, 0, 4'hF, "R11 protected read served");
        // R7: external acknowledge
        run(32'h8060_0000, 0, 0, 4'hF, "R7 ext single");
        run(32'h8060_0040, 0, 1, 4'hF, "R7 ext burst");

        // R12: request held over busy window including final ack
        issue(32'h8060_0100, 0, 1, 4'hF, "R12 busy ignore");
        tick();
        do begin
            req_valid = 1'b1; req_addr = 32'h0000_0000; req_write = 1'b1;
            tick();
        end while (q.size() > 0);
        req_valid = 1'b1;
        tick();
        tick();

        // R4: priority among overlapping channels
        cfg_write(4'd10, 32'h0000_0000);
        cfg_write(4'd11, 32'h000F_FFFF);
        run(32'h0000_0010, 0, 0, 4'hF, "R4 ch0 over ch1");
        cfg_write(4'd10, 32'h8000_0000);
        cfg_write(4'd11, 32'h001F_FFFF);
        run(32'h8000_0000, 0, 0, 4'hF, "R4 ch1 over ch2");
        cfg_write(4'd0, 32'h0000_0000);
        cfg_write(4'd10, 32'h0000_0000);
        cfg_write(4'd11, 32'h000F_FFFF);
        run(32'h0000_0010, 1, 0, 4'hF, "R4 R5 ch0 disabled");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule